// File: doc/BRIEF.md
# Cascadable Up/Down Count Nibble

This block is a synchronous four-bit counter that runs from one shared clock. A direction input selects counting up or counting down. A radix input selects a binary cycle of sixteen states or a decimal cycle of ten states. A parallel load takes a new value on the clock edge and overrides counting. An asynchronous clear input forces the count to zero at once.

The terminal-count strobes are built for chaining. The carry strobe marks an up-count wrap. The borrow strobe marks a down-count wrap. If either strobe is fed into the count enable of the next nibble on the same clock, several nibbles form a longer binary counter or a multi-digit decimal counter. Each strobe depends only on the present count and on the control inputs, so in a chain it lasts exactly one clock cycle.

Top module: `updn_cnt_top`

## Requirements
- R1: While `clr` is 1, `cnt` is 0 at once, with no clock edge needed. Clear takes priority over every other input.
- R2: When `rst` is 1 at a rising clock edge, `cnt` becomes 0 on that edge. Load and counting are ignored on that edge.
- R3: When `load` is 1 at an edge (and neither clear nor reset is active), `cnt` takes the value of `din`. This happens whatever `en`, `dir_up` or `decade` are. Counting then continues from the loaded value.
- R4: When `en` is 0 and `load` is 0, `cnt` keeps its value across the edge.
- R5: In binary mode (`decade`=0) counting up (`dir_up`=1) with `en`=1, the count goes up by one on each edge, and 15 is followed by 0.
- R6: In binary mode counting down (`dir_up`=0) with `en`=1, the count goes down by one on each edge, and 0 is followed by 15.
- R7: In decimal mode (`decade`=1), counting up steps 0..9 and 9 is followed by 0. Counting down steps 9..0 and 0 is followed by 9.
- R8: `carry` is 1 exactly when `en`=1, `dir_up`=1 and `cnt` equals the top value (15 in binary, 9 in decimal). It depends on these inputs combinationally.
- R9: `borrow` is 1 exactly when `en`=1, `dir_up`=0 and `cnt`=0. It depends on these inputs combinationally.
- R10: In decimal mode, an enabled up-count from a value above 9 gives 0, and an enabled down-count from a value above 9 gives that value minus one. `decade` is read on every edge, so switching to decimal mode while the count is above 9 follows the same rule.
- R11: `cnt_msb` always equals bit 3 of `cnt`.
- R12: When the `carry` or `borrow` of one instance drives the `en` of a second instance on the same clock, the second instance steps once per wrap of the first, in the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Asynchronous clear, active high |
| en | input | 1 | Count enable |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| decade | input | 1 | 1 = decimal cycle, 0 = binary cycle |
| load | input | 1 | Parallel load strobe |
| din | input | 4 | Parallel load value |
| cnt | output | 4 | Present count |
| cnt_msb | output | 1 | Most significant count bit |
| carry | output | 1 | Up-count terminal strobe |
| borrow | output | 1 | Down-count terminal strobe |

## Verification
The bench uses two chained instances. It runs long up-count and down-count sequences in binary mode, so that the low nibble wraps both ways and the wrap timing and the step direction of the high nibble can be checked. Decimal sequences in both directions show whether the top value is 9 or 15. Values above 9 are loaded, and the radix is switched while the count is above 9. These cases test the out-of-range rule in each direction. The remaining cases are these:
- A load with enable high shows that load has priority over counting.
- Enable held low at the terminal value tells a held count apart from a strobe that is gated wrongly.
- A clear applied between clock edges shows that the clear acts asynchronously.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    localparam int unsigned NIBBLE_W  = 4;
    localparam int unsigned DEC_TOP   = 9;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic {
        RADIX_BIN = 1'b0,
        RADIX_DEC = 1'b1
    } radix_e;

    typedef struct packed {
        logic   load;
        logic   en;
        dir_e   dir;
        radix_e radix;
    } ctl_t;

    typedef struct packed {
        logic carry;
        logic borrow;
    } term_t;

endpackage

// File: rtl/updn_next_calc.sv
module updn_next_calc
    import updn_cnt_pkg::*;
#(
    parameter int unsigned W        = NIBBLE_W,
    parameter int unsigned DEC_LAST = DEC_TOP
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] din,
    input  ctl_t         ctl,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] DEC_V    = (DEC_LAST >= (1 << W)) ? ALL_ONES : W'(DEC_LAST);

    logic [W-1:0] top_v;
    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;

    always_comb begin
        top_v = (ctl.radix == RADIX_DEC) ? DEC_V : ALL_ONES;
        up_v  = (cnt >= top_v) ? '0 : cnt + 1'b1;
        dn_v  = (cnt == '0) ? top_v : cnt - 1'b1;
    end

    always_comb begin
        if (ctl.load) begin
            nxt = din;
        end else if (!ctl.en) begin
            nxt = cnt;
        end else if (ctl.dir == DIR_UP) begin
            nxt = up_v;
        end else begin
            nxt = dn_v;
        end
    end

endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect
    import updn_cnt_pkg::*;
#(
    parameter int unsigned W        = NIBBLE_W,
    parameter int unsigned DEC_LAST = DEC_TOP
) (
    input  logic [W-1:0] cnt,
    input  ctl_t         ctl,
    output term_t        term
);

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] DEC_V    = (DEC_LAST >= (1 << W)) ? ALL_ONES : W'(DEC_LAST);

    logic at_top;
    logic at_zero;

    always_comb begin
        at_top      = (ctl.radix == RADIX_DEC) ? (cnt == DEC_V) : (cnt == ALL_ONES);
        at_zero     = (cnt == '0);
        term.carry  = ctl.en && (ctl.dir == DIR_UP)   && at_top;
        term.borrow = ctl.en && (ctl.dir == DIR_DOWN) && at_zero;
    end

endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            cnt <= '0;
        end else if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/updn_cnt_top.sv
module updn_cnt_top
    import updn_cnt_pkg::*;
#(
    parameter int unsigned W        = NIBBLE_W,
    parameter int unsigned DEC_LAST = DEC_TOP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         dir_up,
    input  logic         decade,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt,
    output logic         cnt_msb,
    output logic         carry,
    output logic         borrow
);

    ctl_t         ctl;
    term_t        term;
    logic [W-1:0] nxt;
    logic [W-1:0] cur;

    always_comb begin
        ctl.load  = load;
        ctl.en    = en;
        ctl.dir   = dir_e'(dir_up);
        ctl.radix = radix_e'(decade);
    end

    updn_next_calc #(.W(W), .DEC_LAST(DEC_LAST)) u_next (
        .cnt (cur),
        .din (din),
        .ctl (ctl),
        .nxt (nxt)
    );

    updn_term_detect #(.W(W), .DEC_LAST(DEC_LAST)) u_term (
        .cnt  (cur),
        .ctl  (ctl),
        .term (term)
    );

    updn_state_reg #(.W(W)) u_reg (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .nxt (nxt),
        .cnt (cur)
    );

    assign cnt     = cur;
    assign cnt_msb = cur[W-1];
    assign carry   = term.carry;
    assign borrow  = term.borrow;

endmodule

// File: rtl/updn_cnt_chk.sv
module updn_cnt_chk #(
    parameter int unsigned W        = 4,
    parameter int unsigned DEC_LAST = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         clr,
    input logic         en,
    input logic         dir_up,
    input logic         decade,
    input logic         load,
    input logic [W-1:0] din,
    input logic [W-1:0] cnt,
    input logic         carry,
    input logic         borrow
);

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] DV       = (DEC_LAST >= (1 << W)) ? ALL_ONES : W'(DEC_LAST);

    p_clear_zero_r1: assert property (@(posedge clk) clr |-> (cnt == '0));

    p_sync_reset_r2: assert property (@(posedge clk) disable iff (clr)
        rst |=> (cnt == '0));

    p_load_take_r3: assert property (@(posedge clk) disable iff (rst || clr)
        load |=> (cnt == $past(din)));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst || clr)
        (!en && !load) |=> $stable(cnt));

    p_carry_wrap_r8: assert property (@(posedge clk) disable iff (rst || clr)
        (carry && !load) |=> (cnt == '0));

    p_carry_narrow_r8: assert property (@(posedge clk) disable iff (rst || clr)
        (carry && !load) |=> !carry);

    p_borrow_wrap_r9: assert property (@(posedge clk) disable iff (rst || clr)
        (borrow && !load) |=> (cnt == ($past(decade) ? DV : ALL_ONES)));

    p_dec_overrange_r10: assert property (@(posedge clk) disable iff (rst || clr)
        (en && !load && dir_up && decade && (cnt > DV)) |=> (cnt == '0));

endmodule

bind updn_cnt_top updn_cnt_chk #(.W(W), .DEC_LAST(DEC_LAST)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .en     (en),
    .dir_up (dir_up),
    .decade (decade),
    .load   (load),
    .din    (din),
    .cnt    (cnt),
    .carry  (carry),
    .borrow (borrow)
);

// File: tb/updn_cnt_top_tb_top.sv
module updn_cnt_top_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, clr, en, up, dec, ld;
    logic [3:0] din, din_hi;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_msb, hi_msb, lo_cy, lo_bw, hi_cy, hi_bw;
    logic       hi_en;

    assign hi_en = lo_cy | lo_bw;

    updn_cnt_top dut_i (
        .clk(clk), .rst(rst), .clr(clr), .en(en), .dir_up(up), .decade(dec),
        .load(ld), .din(din), .cnt(lo_cnt), .cnt_msb(lo_msb),
        .carry(lo_cy), .borrow(lo_bw)
    );

    updn_cnt_top hi_i (
        .clk(clk), .rst(rst), .clr(clr), .en(hi_en), .dir_up(up), .decade(dec),
        .load(ld), .din(din_hi), .cnt(hi_cnt), .cnt_msb(hi_msb),
        .carry(hi_cy), .borrow(hi_bw)
    );

    typedef struct {
        logic [3:0] lo;
        logic [3:0] hi;
        logic       cy, bw, hcy, hbw;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         fails  = 0;
    logic [3:0] m_lo, m_hi;
    bit         done = 1'b0;

    function automatic logic [3:0] mdl_next(input logic [3:0] c, input logic e, u, d, l,
                                            input logic [3:0] v);
        logic [3:0] top;
        top = d ? 4'd9 : 4'd15;
        if (l)       return v;
        if (!e)      return c;
        if (u)       return (c >= top) ? 4'd0 : c + 4'd1;
        return (c == 4'd0) ? top : c - 4'd1;
    endfunction

    task automatic step(input logic r, c, e, u, d, l, input logic [3:0] v, vh,
                        input string tag);
        exp_t       it;
        logic [3:0] top;
        logic       he;
        @(negedge clk);
        rst = r; clr = c; en = e; up = u; dec = d; ld = l; din = v; din_hi = vh;
        if (c) begin
            m_lo = 4'd0;
            m_hi = 4'd0;
        end
        top    = d ? 4'd9 : 4'd15;
        it.cy  = e && u && (m_lo == top);
        it.bw  = e && !u && (m_lo == 4'd0);
        he     = it.cy | it.bw;
        it.hcy = he && u && (m_hi == top);
        it.hbw = he && !u && (m_hi == 4'd0);
        if (r || c) begin
            m_lo = 4'd0;
            m_hi = 4'd0;
        end else begin
            m_lo = mdl_next(m_lo, e, u, d, l, v);
            m_hi = mdl_next(m_hi, he, u, d, l, vh);
        end
        it.lo  = m_lo;
        it.hi  = m_hi;
        it.tag = tag;
        q.push_back(it);
        if (c) begin
            #3;
            checks++;
            if (lo_cnt !== 4'd0 || hi_cnt !== 4'd0) begin
                fails++;
                $display("FAIL R1 async clear: actual lo=%0d hi=%0d expected lo=0 hi=0",
                         lo_cnt, hi_cnt);
            end
        end
    endtask

    // monitor: strobes before the edge, count after it
    initial begin
        logic s_cy, s_bw, s_hcy, s_hbw;
        exp_t it;
        forever begin
            @(negedge clk);
            #5;
            s_cy = lo_cy; s_bw = lo_bw; s_hcy = hi_cy; s_hbw = hi_bw;
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (lo_cnt !== it.lo || hi_cnt !== it.hi || s_cy !== it.cy ||
                    s_bw !== it.bw || s_hcy !== it.hcy || s_hbw !== it.hbw ||
                    lo_msb !== it.lo[3] || hi_msb !== it.hi[3]) begin
                    fails++;
                    $display("FAIL %s (R11 msb): actual lo=%0d hi=%0d cy=%b bw=%b hcy=%b hbw=%b msb=%b/%b expected lo=%0d hi=%0d cy=%b bw=%b hcy=%b hbw=%b",
                             it.tag, lo_cnt, hi_cnt, s_cy, s_bw, s_hcy, s_hbw, lo_msb, hi_msb,
                             it.lo, it.hi, it.cy, it.bw, it.hcy, it.hbw);
                end
            end
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clr = 1'b0; en = 1'b0; up = 1'b1; dec = 1'b0; ld = 1'b0;
        din = '0; din_hi = '0;
        m_lo = '0; m_hi = '0;
        step(1, 0, 1, 1, 0, 0, 4'd0, 4'd0, "R2 sync reset");
        step(1, 0, 1, 1, 0, 1, 4'd7, 4'd7, "R2 reset beats load");
        for (int i = 0; i < 20; i++) step(0, 0, 1, 1, 0, 0, 0, 0, "R5 R8 R12 binary up");
        step(0, 0, 1, 1, 0, 1, 4'd14, 4'd3, "R3 load beats count");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0, 0, 0, "R3 resume after load");
        step(0, 0, 0, 1, 0, 1, 4'd15, 4'd2, "R3 load with enable low");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, 0, "R4 R8 hold at top");
        for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0, 0, 0, 0, "R6 R9 R12 binary down");
        step(0, 1, 1, 1, 0, 0, 0, 0, "R1 clear");
        for (int i = 0; i < 12; i++) step(0, 0, 1, 1, 1, 0, 0, 0, "R7 R8 decimal up");
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 1, 0, 0, 0, "R7 R9 decimal down");
        step(0, 0, 1, 1, 1, 1, 4'd13, 4'd5, "R10 load 13");
        step(0, 0, 1, 1, 1, 0, 0, 0, "R10 up from 13");
        step(0, 0, 1, 0, 1, 1, 4'd12, 4'd4, "R10 load 12");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 1, 0, 0, 0, "R10 down from 12");
        step(0, 0, 1, 1, 0, 1, 4'd11, 4'd1, "R10 binary load 11");
        step(0, 0, 1, 1, 0, 0, 0, 0, "R5 binary to 12");
        step(0, 0, 1, 1, 1, 0, 0, 0, "R10 switch to decimal above 9");
        step(0, 0, 1, 1, 1, 0, 0, 0, "R7 decimal after switch");
        @(negedge clk);
        ld = 1'b0; en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule